// File: doc/BRIEF.md
# Reed-Solomon Parity Encoder over GF(2^10)

This block produces the eight check symbols of a systematic Reed-Solomon code over GF(2^10), shortened so that 512 data bytes plus 8 parity symbols form one codeword. Each incoming byte is widened to a 10-bit field symbol by zero-extension, and the parity is the remainder of the data polynomial, multiplied by X^8, divided by the generator polynomial. The division is an eight-stage linear feedback shift register whose taps are fixed constant multipliers in the field.

A block is opened with `start`, which clears the division state. Bytes are then offered one per cycle with `valid`. The first byte offered is the highest-power coefficient, so a page is fed from its highest byte address down to address 0. `last` marks the final byte. The encoder then shifts eight zero symbols on its own, raises `done` for one cycle, and presents the 80 parity bits packed little-endian on `ecc`. The value on `ecc` stays there until the next `start`.

Top module: `rs10_ecc_enc`

## Requirements
- R1: After synchronous reset, `done` is 0 and `ecc` is all zeros.
- R2: Field arithmetic is GF(2^10) with reduction polynomial x^10+x^3+1, and x is the primitive element alpha. The generator is the monic polynomial with roots alpha^1 through alpha^8. The parity is the remainder of (data polynomial times X^8) modulo the generator, with each byte zero-extended to 10 bits.
- R3: The first accepted byte of a block is the highest-power coefficient. Cycles with `valid` low inside a block add nothing.
- R4: `ecc` is the concatenation {p7,p6,...,p0} of the ten-bit parity symbols, p0 in bits 9:0. Byte k of the result is bits 8k+7:8k.
- R5: `start` clears the division state. If `valid` is high in the same cycle, that byte becomes the block's first byte.
- R6: `valid`, `data` and `last` have no effect while no block is open, either before any `start` or after `done`. They also have no effect during the eight flush cycles.
- R7: The last byte is accepted at a clock edge. Eight flush edges follow, and `done` is high in the cycle after the eighth of them, for exactly one cycle.
- R8: `ecc` holds its final value from `done` until the next `start`.
- R9: A block of all-zero bytes gives all-zero parity.
- R10: A `start` during an open block or during the flush abandons the old block. The result depends only on bytes from the new `start` onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a block and clears the state |
| valid | input | 1 | `data` carries a byte this cycle |
| last | input | 1 | This byte is the final byte of the block |
| data | input | 8 | Data byte, highest address first |
| ecc | output | 80 | Packed parity, p0 in the low bits |
| done | output | 1 | One-cycle pulse when `ecc` is final |

## Verification
Every cycle, the assertions check the following. A zero feedback symbol yields a zero product. The shift register stays still when it is neither stepped nor cleared, and a clear without a byte leaves it all zero. `done` is a single-cycle pulse, and it is only ever preceded by the flush phase. The arithmetic itself can only be shown by the bench's scenarios. The bench compares `ecc` with a model that builds the generator from its roots. Its scenarios cover random pages with idle gaps, a one-byte block, a restart in the middle of a block, and input activity while the encoder is idle or flushing. The same scenarios show the packing and the done latency.

// File: rtl/rs10_pkg.sv
package rs10_pkg;
    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int NPAR   = 8;
    localparam int ECC_W  = SYM_W * NPAR;
    localparam int CNT_W  = $clog2(NPAR);
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {PH_IDLE, PH_TAKE, PH_FLUSH} phase_e;

    typedef struct packed {
        logic clr;
        logic step;
        sym_t din;
    } lfsr_cmd_t;

    // multiply by alpha (= x) with reduction
    function automatic sym_t gf_times_x(sym_t a);
        sym_t s;
        s = {a[SYM_W-2:0], 1'b0};
        if (a[SYM_W-1]) s = s ^ FIELD_POLY[SYM_W-1:0];
        return s;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        acc = '0;
        for (int i = SYM_W-1; i >= 0; i--) begin
            acc = gf_times_x(acc);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // alpha^k via square-and-multiply
    function automatic sym_t gf_alpha_pow(int unsigned k);
        sym_t res;
        sym_t base;
        res  = sym_t'(1);
        base = sym_t'(2);
        for (int i = 0; i < SYM_W; i++) begin
            if (k[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // log of generator coefficient for X^j (monic, roots alpha^1..alpha^8)
    function automatic int unsigned gen_log(int j);
        case (j)
            0:       return 32'h024;
            1:       return 32'h237;
            2:       return 32'h193;
            3:       return 32'h197;
            4:       return 32'h25F;
            5:       return 32'h18E;
            6:       return 32'h181;
            default: return 32'h21C;
        endcase
    endfunction
endpackage

// File: rtl/rs10_gf_cmul.sv
module rs10_gf_cmul
    import rs10_pkg::*;
#(
    parameter int unsigned EXP = 0
) (
    input  sym_t a,
    output sym_t p
);
    localparam sym_t COEF = gf_alpha_pow(EXP);

    always_comb begin
        p = gf_mul(a, COEF);
    end

    // R2: multiplying by a nonzero constant maps zero to zero and only zero
    always_comb begin
        zero_map_chk: assert ((a == '0) == (p == '0));
    end
endmodule

// File: rtl/rs10_lfsr.sv
module rs10_lfsr
    import rs10_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  lfsr_cmd_t                   cmd,
    output logic [NPAR-1:0][SYM_W-1:0]  par
);
    logic [NPAR-1:0][SYM_W-1:0] r;
    logic [NPAR-1:0][SYM_W-1:0] base;
    logic [NPAR-1:0][SYM_W-1:0] nxt;
    logic [NPAR-1:0][SYM_W-1:0] prod;
    sym_t                       fb;

    always_comb begin
        base = cmd.clr ? '0 : r;
        fb   = base[NPAR-1];
    end

    for (genvar j = 0; j < NPAR; j++) begin : g_tap
        rs10_gf_cmul #(.EXP(gen_log(j))) u_mul (
            .a (fb),
            .p (prod[j])
        );
        if (j == 0) begin : g_in
            always_comb nxt[j] = cmd.din ^ prod[j];
        end else begin : g_mid
            always_comb nxt[j] = base[j-1] ^ prod[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           r <= '0;
        else if (cmd.step) r <= nxt;
        else if (cmd.clr)  r <= '0;
    end

    assign par = r;

    // R6
    // idle_hold_chk: no step and no clear leaves the register unchanged
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd.step && !cmd.clr) |=> $stable(r));

    // R5
    // clear_zero_chk: a clear with no byte empties every stage
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !cmd.step) |=> (r == '0));
endmodule

// File: rtl/rs10_ctrl.sv
module rs10_ctrl
    import rs10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              valid,
    input  logic              last,
    input  logic [BYTE_W-1:0] data,
    output lfsr_cmd_t         cmd,
    output logic              done
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             flushing;

    always_comb begin
        flushing = !start && (phase == PH_FLUSH);
        cmd.clr  = start;
        if (start)                  cmd.step = valid;
        else if (phase == PH_TAKE)  cmd.step = valid;
        else                        cmd.step = (phase == PH_FLUSH);
        cmd.din  = flushing ? '0 : sym_t'(data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= (valid && last) ? PH_FLUSH : PH_TAKE;
                cnt   <= '0;
            end else begin
                case (phase)
                    PH_TAKE: begin
                        if (valid && last) begin
                            phase <= PH_FLUSH;
                            cnt   <= '0;
                        end
                    end
                    PH_FLUSH: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(NPAR-1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    // done_pulse_chk: done never lasts two cycles
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    // done_after_flush_chk: done only follows the flush phase
    done_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(phase == PH_FLUSH));

    // R6
    // flush_steps_chk: every flush cycle without start steps the register with a zero symbol
    flush_steps_chk: assert property (@(posedge clk) disable iff (rst)
        flushing |-> (cmd.step && cmd.din == '0));
endmodule

// File: rtl/rs10_ecc_enc.sv
module rs10_ecc_enc
    import rs10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              valid,
    input  logic              last,
    input  logic [BYTE_W-1:0] data,
    output logic [ECC_W-1:0]  ecc,
    output logic              done
);
    lfsr_cmd_t                  cmd;
    logic [NPAR-1:0][SYM_W-1:0] par;

    rs10_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .valid (valid),
        .last  (last),
        .data  (data),
        .cmd   (cmd),
        .done  (done)
    );

    rs10_lfsr u_lfsr (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .par (par)
    );

    // packed array places p0 in the lowest ten bits
    assign ecc = par;

    // R8
    // ecc_hold_chk: after done the parity stays put until a start
    ecc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(ecc));
endmodule

// File: tb/rs10_ecc_enc_bench.sv
module rs10_ecc_enc_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, valid, last;
    logic [7:0]  data;
    logic [79:0] ecc;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [512];
    logic [9:0] gc [9];

    always #10 clk = ~clk;

    rs10_ecc_enc u_rs10_ecc_enc (
        .clk(clk), .rst(rst), .start(start), .valid(valid),
        .last(last), .data(data), .ecc(ecc), .done(done)
    );

    function automatic logic [9:0] bmul(logic [9:0] a, logic [9:0] b);
        logic [9:0] acc = '0;
        logic [9:0] t = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) acc ^= t;
            t = t[9] ? ({t[8:0], 1'b0} ^ 10'h009) : {t[8:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [9:0] bpow(int k);
        logic [9:0] v = 10'd1;
        for (int i = 0; i < k; i++) v = bmul(v, 10'd2);
        return v;
    endfunction

    task automatic build_gen();
        for (int j = 0; j < 9; j++) gc[j] = (j == 0) ? 10'd1 : 10'd0;
        for (int i = 1; i <= 8; i++) begin
            logic [9:0] a = bpow(i);
            for (int j = 8; j >= 1; j--) gc[j] = gc[j-1] ^ bmul(gc[j], a);
            gc[0] = bmul(gc[0], a);
        end
    endtask

    // division of mem[n-1..0] followed by eight zeros
    function automatic logic [79:0] ref_ecc(int n);
        logic [9:0] r [8];
        logic [79:0] o;
        for (int j = 0; j < 8; j++) r[j] = '0;
        for (int i = n-1; i >= -8; i--) begin
            logic [9:0] d = (i >= 0) ? {2'b00, mem[i]} : 10'd0;
            logic [9:0] f = r[7];
            for (int j = 7; j >= 1; j--) r[j] = r[j-1] ^ bmul(f, gc[j]);
            r[0] = d ^ bmul(f, gc[0]);
        end
        for (int j = 0; j < 8; j++) o[j*10 +: 10] = r[j];
        return o;
    endfunction

    task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 0; valid = 0; last = 0; data = '0;
    endtask

    // feeds mem[n-1]..mem[0]; verifies done timing and ecc
    task automatic run_block(int n, bit gaps, bit first_with_start, bit noise, string req);
        int idx = n - 1;
        logic [79:0] exp = ref_ecc(n);
        @(negedge clk);
        start = 1;
        if (first_with_start) begin
            valid = 1; data = mem[idx]; last = (idx == 0); idx--;
        end else begin
            valid = 0; last = 0;
        end
        @(negedge clk);
        start = 0;
        while (idx >= 0) begin
            if (gaps && ($urandom % 4 == 0)) begin
                valid = 0; last = 0; data = 8'($urandom);
            end else begin
                valid = 1; data = mem[idx]; last = (idx == 0); idx--;
            end
            @(negedge clk);
        end
        for (int k = 0; k < 8; k++) begin
            if (noise) begin
                valid = 1; data = 8'($urandom); last = 1'($urandom);
            end else begin
                valid = 0; last = 0;
            end
            if (k == 7) check(done == 1'b0, {"R7 early done ", req}, {79'd0, done}, 80'd0);
            @(negedge clk);
        end
        idle_inputs();
        check(done == 1'b1, {"R7 done ", req}, {79'd0, done}, 80'd1);
        check(ecc == exp, req, ecc, exp);
        @(negedge clk);
        check(done == 1'b0, "R7 single pulse", {79'd0, done}, 80'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [79:0] held;
        void'($urandom(32'd1234));
        build_gen();
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(done == 0 && ecc == '0, "R1 reset", ecc, 80'd0);

        // R6: inputs before any start do nothing
        repeat (10) begin
            valid = 1; data = 8'($urandom); last = 1'($urandom);
            @(negedge clk);
        end
        idle_inputs();
        check(ecc == '0 && done == 0, "R6 pre-start", ecc, 80'd0);

        // R9: zero page
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        run_block(512, 0, 0, 0, "R9 zero page");
        check(ecc == '0, "R9 zero parity", ecc, 80'd0);

        // R2 R4: single byte 0x01 gives generator low coefficients
        mem[0] = 8'h01;
        run_block(1, 0, 0, 0, "R4 unit byte");
        begin
            logic [79:0] g;
            for (int j = 0; j < 8; j++) g[j*10 +: 10] = gc[j];
            check(ecc == g, "R2 R4 generator taps", ecc, g);
        end

        // R2 R3: random pages, with and without gaps
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
            run_block(512, b[0], 0, 0, "R2 R3 random page");
        end

        // R3: byte order matters (only top byte nonzero vs only bottom)
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[511] = 8'hA5;
        run_block(512, 0, 0, 0, "R3 top byte");

        // R5: start with first byte in same cycle, plus one-byte block
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        run_block(512, 1, 1, 0, "R5 start with data");
        mem[0] = 8'hFF;
        run_block(1, 0, 1, 0, "R5 one byte at start");

        // R6: noise during flush
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        run_block(512, 0, 0, 1, "R6 flush noise");

        // R8 R6: idle activity after done leaves ecc unchanged
        held = ecc;
        repeat (20) begin
            valid = 1; data = 8'($urandom); last = 1'($urandom);
            @(negedge clk);
        end
        idle_inputs();
        check(ecc == held, "R8 hold after done", ecc, held);
        check(done == 0, "R6 no done while idle", {79'd0, done}, 80'd0);

        // R10: abandon a block mid-way, then restart
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (30) begin
            valid = 1; data = 8'($urandom); last = 0;
            @(negedge clk);
        end
        idle_inputs();
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        run_block(512, 0, 0, 0, "R10 restart mid-block");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule